// File: doc/BRIEF.md
# Page-Addressed 12-Bit Accumulator Processor

This block is a small processor core with one 12-bit accumulator and a one-bit link flag. Program and data share a single 4096-word memory, which the core reaches through one synchronous port. An instruction word names its operand by a 7-bit offset. The offset is taken either in zero page (words 0x000 to 0x07F) or in the 128-word page that holds the instruction. One extra memory read can turn that address into a pointer, which reaches any word in the space.

The core has no stack and no subtract instruction. A subroutine call leaves its return address in the first word of the subroutine, and the subroutine returns with an indirect jump through that word. To subtract, software complements the value, increments it and adds it. The only conditional control is to skip the next word. A branch to any address is therefore a skip placed in front of a jump. The core stops when it decodes a halt request, and only reset starts it again.

Top module: `acc12_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the accumulator and the link. During reset and in the first cycle afterwards the memory address is 0x000, the write enable is low and the halt output is low.
- R2: Bits 11:9 of an instruction hold the opcode (0 AND, 1 add, 2 increment-skip, 3 deposit-clear, 4 call, 5 jump, 6 no operation, 7 operate). For a memory-reference instruction, bit 8 selects indirection and bit 7 selects the page (0 zero page, 1 the instruction's own page). The direct address is the 7-bit offset in bits 6:0, placed below the page number.
- R3: When bit 8 is set, the effective address is the word read from the direct address, and it can reach all 4096 words.
- R4: Add forms the two's-complement sum modulo 4096 of the accumulator and the operand, and a carry out of bit 11 inverts the link. AND forms the bitwise AND of the accumulator and the operand.
- R5: Deposit-clear writes the accumulator to the effective address and then clears the accumulator.
- R6: Increment-skip writes the operand plus one back to the effective address. When that result is zero, the next instruction is skipped.
- R7: Call writes the address of the following instruction to the effective address and continues at the effective address plus one. An indirect jump through that word returns to the caller.
- R8: Jump loads the effective address into the program counter. The direct form stays in zero page or the current page.
- R9: In an operate word, bit 8 clears the accumulator, bit 7 clears the link, bit 6 complements the accumulator, bit 5 complements the link and bit 4 increments the accumulator, with a carry inverting the link. These are applied in that order. Bits 3, 2 and 1 skip the next word when the resulting accumulator is zero, when its bit 11 is set, or when the resulting link is set, and any selected condition that holds causes the skip.
- R10: Operate bit 0 halts the core. The halt output then stays high and no memory write occurs until reset.
- R11: Read data arrives one cycle after its address. An instruction takes two cycles for operate, no operation or a direct jump, three for a direct deposit-clear or call, and four for a direct AND, add or increment-skip. Indirection adds one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Word address for read or write |
| mem_rdata | input | 12 | Data of the address presented in the previous cycle |
| mem_wdata | output | 12 | Data to write |
| mem_we | output | 1 | Write strobe for mem_addr at the next rising edge |
| halt | output | 1 | High once a halt has been executed |

## Verification
Increment-skip writes its result back in the same cycle in which it chooses whether the program counter steps once or twice, so these two functions meet in one cycle. The bench provokes this by incrementing a word that holds 0xFFF and placing a halt in the slot that must be skipped. It judges the result by the stored zero and by the later results that only appear if execution went past the halt. A call that goes through a pointer and returns through its own saved word is handled the same way: the bench judges it by the return word kept in memory and by the value that was stored after the return.

// File: rtl/acc12_pkg.sv
package acc12_pkg;
    localparam int W      = 12;
    localparam int OFS_W  = 7;
    localparam int PG_W   = W - OFS_W;
    localparam int OP_W   = 3;
    localparam int CTL_W  = W - OP_W;
    localparam int PAGE_B = OFS_W;
    localparam int IND_B  = OFS_W + 1;

    typedef logic [W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_NOP = 3'd6,
        OP_OPR = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_INDIR  = 3'd2,
        ST_EXEC   = 3'd3,
        ST_EXEC2  = 3'd4,
        ST_HALT   = 3'd5
    } state_e;

    typedef struct packed {
        state_e st;
        word_t  pc;
        word_t  ac;
        logic   lnk;
        op_e    op;
        word_t  ea;
    } regs_t;
endpackage

// File: rtl/acc12_ea.sv
module acc12_ea
    import acc12_pkg::*;
(
    input  logic [PG_W-1:0]  page,
    input  logic             cur_page,
    input  logic [OFS_W-1:0] offset,
    output word_t            ea
);
    always_comb begin
        if (cur_page) ea = {page, offset};
        else          ea = {{PG_W{1'b0}}, offset};
    end
endmodule

// File: rtl/acc12_add.sv
module acc12_add
    import acc12_pkg::*;
(
    input  word_t a,
    input  word_t b,
    output word_t sum,
    output logic  cout
);
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b};
    end
endmodule

// File: rtl/acc12_opr.sv
module acc12_opr
    import acc12_pkg::*;
(
    input  word_t             ac_i,
    input  logic              lnk_i,
    input  logic [CTL_W-1:0]  ctl,
    output word_t             ac_o,
    output logic              lnk_o,
    output logic              skip,
    output logic              hlt
);
    logic [W:0] inc;

    always_comb begin
        ac_o  = ctl[8] ? '0 : ac_i;
        lnk_o = ctl[7] ? 1'b0 : lnk_i;
        if (ctl[6]) ac_o = ~ac_o;
        if (ctl[5]) lnk_o = ~lnk_o;
        inc = {1'b0, ac_o} + {{W{1'b0}}, 1'b1};
        if (ctl[4]) begin
            ac_o  = inc[W-1:0];
            lnk_o = lnk_o ^ inc[W];
        end
        skip = (ctl[3] && (ac_o == '0)) ||
               (ctl[2] && ac_o[W-1]) ||
               (ctl[1] && lnk_o);
        hlt  = ctl[0];
    end
endmodule

// File: rtl/acc12_core.sv
module acc12_core
    import acc12_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [11:0] mem_addr,
    input  logic [11:0] mem_rdata,
    output logic [11:0] mem_wdata,
    output logic        mem_we,
    output logic        halt
);
    regs_t r_d, r_q;

    word_t ea_dir;
    word_t opr_ac;
    logic  opr_lnk, opr_skip, opr_hlt;
    word_t add_sum;
    logic  add_cout;
    word_t inc_val;
    op_e   dec_op;

    acc12_ea u_ea (
        .page     (r_q.pc[W-1:OFS_W]),
        .cur_page (mem_rdata[PAGE_B]),
        .offset   (mem_rdata[OFS_W-1:0]),
        .ea       (ea_dir)
    );

    acc12_opr u_opr (
        .ac_i  (r_q.ac),
        .lnk_i (r_q.lnk),
        .ctl   (mem_rdata[CTL_W-1:0]),
        .ac_o  (opr_ac),
        .lnk_o (opr_lnk),
        .skip  (opr_skip),
        .hlt   (opr_hlt)
    );

    acc12_add u_add (
        .a    (r_q.ac),
        .b    (mem_rdata),
        .sum  (add_sum),
        .cout (add_cout)
    );

    assign dec_op  = op_e'(mem_rdata[W-1:W-OP_W]);
    assign inc_val = mem_rdata + word_t'(1);
    assign halt    = (r_q.st == ST_HALT);

    always_comb begin
        r_d       = r_q;
        mem_addr  = r_q.pc;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (r_q.st)
            ST_FETCH: begin
                mem_addr = r_q.pc;
                r_d.st   = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.op = dec_op;
                r_d.pc = r_q.pc + word_t'(1);
                if (dec_op == OP_OPR) begin
                    r_d.ac  = opr_ac;
                    r_d.lnk = opr_lnk;
                    if (opr_skip) r_d.pc = r_q.pc + word_t'(2);
                    r_d.st = opr_hlt ? ST_HALT : ST_FETCH;
                end else if (dec_op == OP_NOP) begin
                    r_d.st = ST_FETCH;
                end else if (mem_rdata[IND_B]) begin
                    mem_addr = ea_dir;
                    r_d.st   = ST_INDIR;
                end else if (dec_op == OP_JMP) begin
                    r_d.pc = ea_dir;
                    r_d.st = ST_FETCH;
                end else begin
                    r_d.ea = ea_dir;
                    r_d.st = ST_EXEC;
                end
            end
            ST_INDIR: begin
                r_d.ea = mem_rdata;
                if (r_q.op == OP_JMP) begin
                    r_d.pc = mem_rdata;
                    r_d.st = ST_FETCH;
                end else begin
                    r_d.st = ST_EXEC;
                end
            end
            ST_EXEC: begin
                mem_addr = r_q.ea;
                r_d.st   = ST_FETCH;
                case (r_q.op)
                    OP_DCA: begin
                        mem_we    = 1'b1;
                        mem_wdata = r_q.ac;
                        r_d.ac    = '0;
                    end
                    OP_JMS: begin
                        mem_we    = 1'b1;
                        mem_wdata = r_q.pc;
                        r_d.pc    = r_q.ea + word_t'(1);
                    end
                    default: r_d.st = ST_EXEC2;
                endcase
            end
            ST_EXEC2: begin
                mem_addr = r_q.ea;
                r_d.st   = ST_FETCH;
                case (r_q.op)
                    OP_AND: r_d.ac = r_q.ac & mem_rdata;
                    OP_TAD: begin
                        r_d.ac  = add_sum;
                        r_d.lnk = r_q.lnk ^ add_cout;
                    end
                    OP_ISZ: begin
                        mem_we    = 1'b1;
                        mem_wdata = inc_val;
                        if (inc_val == '0) r_d.pc = r_q.pc + word_t'(1);
                    end
                    default: ;
                endcase
            end
            ST_HALT: r_d.st = ST_HALT;
            default: r_d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= ST_FETCH;
            r_q.pc  <= '0;
            r_q.ac  <= '0;
            r_q.lnk <= 1'b0;
            r_q.op  <= OP_NOP;
            r_q.ea  <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/acc12_checker.sv
module acc12_checker (
    input logic        clk,
    input logic        rst,
    input logic [11:0] mem_addr,
    input logic        mem_we,
    input logic        halt
);
    // R10: once raised, halt stays high until reset
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R10: no memory write while halted
    a_r10_no_write_halted: assert property (@(posedge clk) disable iff (rst)
        halt |-> !mem_we);

    // R1: the first cycle after reset fetches from address zero
    a_r1_first_fetch: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == 12'h000 && !mem_we && !halt));

    // R5: every store is followed by a cycle without a store
    a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
endmodule

bind acc12_core acc12_checker i_acc12_checker (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halt     (halt)
);

// File: tb/test_acc12_core.sv
module test_acc12_core;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_we, halt;
    logic [11:0] mem [MEM_WORDS];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc12_core i_acc12_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .halt      (halt)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[8:0]];
    end

    function automatic logic [11:0] mr(int op, int ind, int pg, int ofs);
        return {op[2:0], ind[0], pg[0], ofs[6:0]};
    endfunction

    function automatic logic [11:0] opr(logic [8:0] bits);
        return {3'd7, bits};
    endfunction

    localparam logic [8:0] CLA = 9'h100, CLL = 9'h080, CMA = 9'h040, CML = 9'h020,
                           IAC = 9'h010, SZA = 9'h008, SMA = 9'h004, SNL = 9'h002,
                           HLT = 9'h001;

    task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 12'h000;
    endtask

    task automatic do_reset(bit check);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        if (check) begin
            chk("R1 addr in reset", mem_addr, 12'h000);
            chk("R1 we in reset", {11'b0, mem_we}, 12'h000);
            chk("R1 halt in reset", {11'b0, halt}, 12'h000);
        end
        rst = 1'b0;
    endtask

    task automatic run(output int n);
        n = 0;
        while (!halt && n < 3000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_sticky();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R10 halt held", {11'b0, halt}, 12'h001);
            if (mem_we) chk("R10 write while halted", 12'h001, 12'h000);
        end
    endtask

    task automatic prog_arith(logic [11:0] a, logic [11:0] b);
        int n;
        logic [12:0] s;
        clear_mem();
        mem[0]  = opr(CLA | CLL);
        mem[1]  = mr(1, 0, 0, 7'h40);
        mem[2]  = mr(1, 0, 0, 7'h41);
        mem[3]  = mr(3, 0, 0, 7'h42);
        mem[4]  = opr(SNL);
        mem[5]  = mr(5, 0, 0, 7);
        mem[6]  = mr(2, 0, 0, 7'h43);
        mem[7]  = opr(CLA | CLL);
        mem[8]  = mr(1, 0, 0, 7'h41);
        mem[9]  = opr(CMA | IAC);
        mem[10] = mr(1, 0, 0, 7'h40);
        mem[11] = mr(3, 0, 0, 7'h44);
        mem[12] = mr(1, 0, 0, 7'h40);
        mem[13] = mr(0, 0, 0, 7'h41);
        mem[14] = mr(3, 0, 0, 7'h45);
        mem[15] = opr(HLT);
        mem[9'h40] = a;
        mem[9'h41] = b;
        do_reset(1'b0);
        run(n);
        s = {1'b0, a} + {1'b0, b};
        chk("R4 sum", mem[9'h42], s[11:0]);
        chk("R4 carry to link", mem[9'h43], {11'b0, s[12]});
        chk("R9 negate then add", mem[9'h44], a - b);
        chk("R4 and", mem[9'h45], a & b);
        chk("R5 operand kept", mem[9'h40], a);
    endtask

    task automatic prog_flow();
        int n;
        clear_mem();
        mem[0]  = opr(CLA | CLL);
        mem[1]  = mr(1, 0, 0, 7'h50);
        mem[2]  = mr(4, 1, 0, 7'h51);
        mem[3]  = mr(3, 0, 0, 7'h52);
        mem[4]  = mr(2, 0, 0, 7'h53);
        mem[5]  = opr(HLT);
        mem[6]  = mr(1, 0, 0, 7'h54);
        mem[7]  = opr(SMA);
        mem[8]  = opr(HLT);
        mem[9]  = mr(3, 0, 0, 7'h55);
        mem[10] = opr(SZA);
        mem[11] = opr(HLT);
        mem[12] = mr(5, 1, 0, 7'h56);
        mem[9'h101] = mr(1, 0, 1, 7'h7F);
        mem[9'h102] = mr(0, 0, 0, 7'h57);
        mem[9'h103] = mr(5, 1, 1, 7'h00);
        mem[9'h17F] = 12'h00A;
        mem[9'h180] = mr(2, 0, 0, 7'h58);
        mem[9'h181] = opr(CMA | CML);
        mem[9'h182] = opr(HLT);
        mem[9'h183] = mr(2, 0, 0, 7'h58);
        mem[9'h50] = 12'h005;
        mem[9'h51] = 12'h100;
        mem[9'h53] = 12'hFFF;
        mem[9'h54] = 12'h800;
        mem[9'h56] = 12'h180;
        mem[9'h57] = 12'h00C;
        mem[9'h58] = 12'h005;
        do_reset(1'b1);
        run(n);
        chk("R7 return word saved", mem[9'h100], 12'h003);
        chk("R2 current page and zero page operands", mem[9'h52], 12'h00C);
        chk("R6 increment wraps to zero", mem[9'h53], 12'h000);
        chk("R9 skip on negative then zero", mem[9'h55], 12'h800);
        chk("R3 R8 indirect jump reached target", mem[9'h58], 12'h006);
        chk("R10 halt raised", {11'b0, halt}, 12'h001);
        check_sticky();
    endtask

    task automatic prog_reset_state();
        int n;
        clear_mem();
        mem[0] = mr(3, 0, 0, 7'h60);
        mem[1] = opr(SNL);
        mem[2] = mr(5, 0, 0, 4);
        mem[3] = mr(2, 0, 0, 7'h61);
        mem[4] = opr(HLT);
        mem[9'h60] = 12'h5A5;
        do_reset(1'b1);
        run(n);
        chk("R1 accumulator cleared", mem[9'h60], 12'h000);
        chk("R1 link cleared", mem[9'h61], 12'h000);
        chk("R11 cycle count", n[11:0], 12'd9);
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        prog_flow();
        prog_reset_state();
        prog_arith(12'hFFF, 12'h001);
        prog_arith(12'h000, 12'h000);
        prog_arith(12'h800, 12'h800);
        for (int i = 0; i < 30; i++) begin
            logic [11:0] a, b;
            a = 12'($urandom());
            b = 12'($urandom());
            prog_arith(a, b);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 12'h000, 12'h001);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule